// File: doc/BRIEF.md
# Scan-chained DES round state register

This block holds the 64-bit plaintext input register and the 32-bit left and right halves of an iterative DES datapath. Each of these 128 flip-flops has a two-way multiplexer at its D input, so the same storage acts either as the functional state of the cipher or as one serial shift register for design-for-test. While `scan_enable` is low, the flip-flops capture functional data. The input register loads a plaintext on `pt_load`. The L/R pair takes one Feistel round on `step`, starting either from the initial permutation of the input register or from its own current contents. While `scan_enable` is high, every flip-flop is cut off from the round logic and the chain moves one bit per clock.

A test program can load a plaintext, run one functional clock, shift the whole state out, and run the next functional clock. These steps can alternate one cycle at a time. This makes the round-1 L/R values observable at `scan_out`, and it shows the one-bit and two-bit difference patterns that a flipped plaintext bit leaves in the state.

Top module: `scan_des_state`

## Requirements
- R1: While `rst` is high at a clock edge, all 128 chained flip-flops clear to zero.
- R2: With `scan_enable` low, `pt_load` high makes the input register capture `pt_in`. With `pt_load` low, the input register holds its value.
- R3: With `scan_enable` low, `step` high and `from_input` high, the L/R pair becomes one DES round applied to IP(input register) with `round_key` as K1. For plaintext 0123456789ABCDEF and key 1B02EFFC7072, this gives L = F0AAF0AA and R = EF4A6544.
- R4: With `scan_enable` low, `step` high and `from_input` low, the L/R pair takes one more round from its own contents. Starting from R3's result with key 79AED9DBC9E5, this gives L = EF4A6544 and R = CC017709.
- R5: After any round, the new L equals the R that fed the round.
- R6: With `scan_enable` high, the chain shifts one bit per clock. `scan_in` enters input-register bit 63, the bits move from bit 63 down to bit 0, then through L bits 31..0 and then R bits 31..0, and `scan_out` shows R bit 0. `pt_load`, `step` and `pt_in` have no effect during a shift. The k-th bit read at `scan_out` (k = 0 before the first shift) is chain bit k, where chain = {input, L, R}. The k-th bit shifted in lands in chain bit k after 128 shifts.
- R7: 128 shifts with `scan_out` fed back to `scan_in` restore all 128 bits exactly.
- R8: Flipping plaintext bit i changes exactly one scanned input-register bit, namely bit i. After one round from the input register, an even i leaves L unchanged and changes exactly one bit of R. An odd i changes exactly one bit of L.
- R9: While `scan_enable` is low, `scan_in` has no effect on any state.
- R10: With `scan_enable` low and `step` low, L and R hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_enable | input | 1 | 1 = serial shift, 0 = functional capture |
| scan_in | input | 1 | Serial data into input-register bit 63 |
| pt_in | input | 64 | Plaintext block |
| pt_load | input | 1 | Capture `pt_in` into the input register |
| round_key | input | 48 | Round subkey for the round being taken |
| step | input | 1 | Take one round into L/R |
| from_input | input | 1 | Round source: 1 = IP(input register), 0 = current L/R |
| scan_out | output | 1 | Serial data out, R bit 0 |

## Verification
A wrong multiplexer select or a broken chain link shows up at `scan_out` within one unload. Such a fault either displaces or corrupts a bit of the 128-bit pattern, or it leaves the state changed after a looped-back rotation. A fault in the permutation, expansion, substitution or key mixing is seen at the first unload after a round. The round-1 and round-2 known answers then differ, and a single flipped plaintext bit no longer gives the one-bit and two-bit difference counts in the expected half. A stray capture during shift or a stray shift during capture corrupts the pattern that a later unload reads back.

// File: rtl/scan_des_pkg.sv
package scan_des_pkg;

    localparam int BLK_W  = 64;
    localparam int HALF_W = BLK_W / 2;
    localparam int KEY_W  = 48;
    localparam int CHAIN_W = BLK_W + 2 * HALF_W;

    typedef struct packed {
        logic [HALF_W-1:0] l;
        logic [HALF_W-1:0] r;
    } half_pair_t;

    // substitution boxes, row-major (row*16+col), first entry in top nibble
    localparam logic [255:0] SBOX [8] = '{
        256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
        256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
        256'hA09E63F51DC7B428_D70934A6285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
        256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
        256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
        256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
        256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
        256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B
    };

    // positions are counted 1..N from the most significant bit
    function automatic half_pair_t ip_perm(input logic [BLK_W-1:0] x);
        logic [BLK_W-1:0] y;
        for (int o = 0; o < BLK_W; o++) begin
            int row;
            int src;
            row = o / 8;
            src = ((row < 4) ? (58 + 2 * row) : (57 + 2 * (row - 4))) - 8 * (o % 8);
            y[BLK_W-1-o] = x[BLK_W-src];
        end
        return y;
    endfunction

    function automatic logic [KEY_W-1:0] expand(input logic [HALF_W-1:0] x);
        logic [KEY_W-1:0] y;
        for (int g = 0; g < 8; g++) begin
            for (int j = 0; j < 6; j++) begin
                int src;
                src = 4 * g + j;
                if (src == 0) src = HALF_W;
                if (src == HALF_W + 1) src = 1;
                y[KEY_W-1-(6*g+j)] = x[HALF_W-src];
            end
        end
        return y;
    endfunction

    function automatic int p_src(input int o);
        case (o)
            0: return 16;   1: return 7;   2: return 20;  3: return 21;
            4: return 29;   5: return 12;  6: return 28;  7: return 17;
            8: return 1;    9: return 15; 10: return 23; 11: return 26;
            12: return 5;  13: return 18; 14: return 31; 15: return 10;
            16: return 2;  17: return 8;  18: return 24; 19: return 14;
            20: return 32; 21: return 27; 22: return 3;  23: return 9;
            24: return 19; 25: return 13; 26: return 30; 27: return 6;
            28: return 22; 29: return 11; 30: return 4;  default: return 25;
        endcase
    endfunction

    function automatic logic [HALF_W-1:0] p_perm(input logic [HALF_W-1:0] x);
        logic [HALF_W-1:0] y;
        for (int o = 0; o < HALF_W; o++) y[HALF_W-1-o] = x[HALF_W-p_src(o)];
        return y;
    endfunction

    function automatic logic [3:0] sbox_lookup(input int b, input logic [5:0] six);
        int idx;
        idx = {26'd0, six[5], six[0], six[4:1]};
        return SBOX[b][255-4*idx -: 4];
    endfunction

endpackage

// File: rtl/scan_seg.sv
module scan_seg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             se,
    input  logic             si,
    input  logic             cap,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic             so
);
    // each bit: select 1 takes the upstream neighbour, select 0 the functional value
    always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (se)  q <= {si, q[WIDTH-1:1]};
        else if (cap) q <= d;
    end

    assign so = q[0];
endmodule

// File: rtl/des_feistel.sv
module des_feistel
    import scan_des_pkg::*;
(
    input  half_pair_t       src,
    input  logic [KEY_W-1:0] key,
    output half_pair_t       dst
);
    logic [KEY_W-1:0]  mixed;
    logic [HALF_W-1:0] subst;

    assign mixed = expand(src.r) ^ key;

    generate
        for (genvar b = 0; b < 8; b++) begin : g_box
            assign subst[HALF_W-1-4*b -: 4] = sbox_lookup(b, mixed[KEY_W-1-6*b -: 6]);
        end
    endgenerate

    assign dst.l = src.r;
    assign dst.r = src.l ^ p_perm(subst);
endmodule

// File: rtl/scan_des_state.sv
module scan_des_state
    import scan_des_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             scan_enable,
    input  logic             scan_in,
    input  logic [BLK_W-1:0] pt_in,
    input  logic             pt_load,
    input  logic [KEY_W-1:0] round_key,
    input  logic             step,
    input  logic             from_input,
    output logic             scan_out
);
    logic [BLK_W-1:0]  in_q;
    logic [HALF_W-1:0] l_q;
    logic [HALF_W-1:0] r_q;
    logic              so_in;
    logic              so_l;
    half_pair_t        rnd_src;
    half_pair_t        rnd_dst;

    always_comb begin
        if (from_input) rnd_src = ip_perm(in_q);
        else            rnd_src = '{l: l_q, r: r_q};
    end

    des_feistel u_round (
        .src (rnd_src),
        .key (round_key),
        .dst (rnd_dst)
    );

    scan_seg #(.WIDTH(BLK_W)) u_seg_in (
        .clk (clk), .rst (rst), .se (scan_enable), .si (scan_in),
        .cap (pt_load), .d (pt_in), .q (in_q), .so (so_in)
    );

    scan_seg #(.WIDTH(HALF_W)) u_seg_l (
        .clk (clk), .rst (rst), .se (scan_enable), .si (so_in),
        .cap (step), .d (rnd_dst.l), .q (l_q), .so (so_l)
    );

    scan_seg #(.WIDTH(HALF_W)) u_seg_r (
        .clk (clk), .rst (rst), .se (scan_enable), .si (so_l),
        .cap (step), .d (rnd_dst.r), .q (r_q), .so (scan_out)
    );
endmodule

// File: rtl/scan_des_state_chk.sv
module scan_des_state_chk (
    input logic        clk,
    input logic        rst,
    input logic        scan_enable,
    input logic        scan_in,
    input logic        pt_load,
    input logic        step,
    input logic        from_input,
    input logic        scan_out,
    input logic [63:0] in_q,
    input logic [31:0] l_q,
    input logic [31:0] r_q
);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (in_q == 64'd0 && l_q == 32'd0 && r_q == 32'd0));

    a_r6_head_takes_scan_in: assert property (@(posedge clk) disable iff (rst)
        scan_enable |=> in_q[63] == $past(scan_in));

    a_r6_link_in_to_l: assert property (@(posedge clk) disable iff (rst)
        scan_enable |=> l_q[31] == $past(in_q[0]));

    a_r6_tail_to_out: assert property (@(posedge clk) disable iff (rst)
        scan_enable |=> scan_out == $past(r_q[1]));

    a_r2_input_hold: assert property (@(posedge clk) disable iff (rst)
        (!scan_enable && !pt_load) |=> $stable(in_q));

    a_r5_l_gets_r: assert property (@(posedge clk) disable iff (rst)
        (!scan_enable && step && !from_input) |=> l_q == $past(r_q));

    a_r10_lr_hold: assert property (@(posedge clk) disable iff (rst)
        (!scan_enable && !step) |=> ($stable(l_q) && $stable(r_q)));
endmodule

bind scan_des_state scan_des_state_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .scan_enable (scan_enable),
    .scan_in     (scan_in),
    .pt_load     (pt_load),
    .step        (step),
    .from_input  (from_input),
    .scan_out    (scan_out),
    .in_q        (in_q),
    .l_q         (l_q),
    .r_q         (r_q)
);

// File: tb/sim_scan_des_state.sv
`timescale 1ns/100ps
module sim_scan_des_state;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scan_enable = 1'b0;
    logic        scan_in = 1'b0;
    logic [63:0] pt_in = '0;
    logic        pt_load = 1'b0;
    logic [47:0] round_key = '0;
    logic        step = 1'b0;
    logic        from_input = 1'b0;
    logic        scan_out;

    int vectors = 0;
    int miscomp = 0;
    bit finished = 0;

    localparam logic [63:0] PT = 64'h0123456789ABCDEF;
    localparam logic [47:0] K1 = 48'h1B02EFFC7072;
    localparam logic [47:0] K2 = 48'h79AED9DBC9E5;
    localparam logic [31:0] L1 = 32'hF0AAF0AA;
    localparam logic [31:0] R1 = 32'hEF4A6544;
    localparam logic [31:0] R2 = 32'hCC017709;

    scan_des_state u0 (
        .clk(clk), .rst(rst), .scan_enable(scan_enable), .scan_in(scan_in),
        .pt_in(pt_in), .pt_load(pt_load), .round_key(round_key), .step(step),
        .from_input(from_input), .scan_out(scan_out)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        vectors++;
        if (!ok) begin
            miscomp++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_eq(input string tag, input logic [127:0] act, input logic [127:0] exp);
        check(act == exp, tag, act, exp);
    endtask

    // one functional clock; called and returns at a negedge
    task automatic func(input logic ld, input logic [63:0] pt, input logic st,
                        input logic fi, input logic [47:0] k, input logic si);
        pt_load = ld; pt_in = pt; step = st; from_input = fi; round_key = k; scan_in = si;
        @(posedge clk); @(negedge clk);
        pt_load = 1'b0; step = 1'b0; scan_in = 1'b0;
    endtask

    // 128 shifts; loop=1 feeds scan_out back, else fill[k] is shifted in as bit k
    // functional inputs are driven with junk to show they are ignored
    task automatic unload(output logic [127:0] c, input logic [127:0] fill, input bit loop);
        scan_enable = 1'b1;
        pt_load = 1'b1; step = 1'b1; pt_in = 64'hDEADBEEFCAFEF00D; from_input = 1'b1;
        for (int k = 0; k < 128; k++) begin
            c[k] = scan_out;
            scan_in = loop ? scan_out : fill[k];
            @(posedge clk); @(negedge clk);
        end
        scan_enable = 1'b0; pt_load = 1'b0; step = 1'b0; scan_in = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            vectors++; miscomp++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
            $finish;
        end
    end

    initial begin
        logic [127:0] c;
        logic [127:0] c2;
        logic [127:0] pat;
        logic [63:0]  d;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check_eq("R1 scan_out after reset", {127'd0, scan_out}, 128'd0);
        unload(c, '0, 1'b1);
        check_eq("R1 chain after reset", c, 128'd0);

        // R2, R3, R5: load and first round from the input register
        func(1'b1, PT, 1'b0, 1'b0, '0, 1'b0);
        func(1'b0, 64'hFFFF0000FFFF0000, 1'b1, 1'b1, K1, 1'b0);
        unload(c, '0, 1'b1);
        check_eq("R2 input register", {64'd0, c[127:64]}, {64'd0, PT});
        check_eq("R3 round1 R", {96'd0, c[31:0]}, {96'd0, R1});
        check_eq("R5 round1 L equals R0", {96'd0, c[63:32]}, {96'd0, L1});

        // R7: looped unload left the state intact; R4/R5 reinject round
        func(1'b0, '0, 1'b1, 1'b0, K2, 1'b0);
        unload(c, '0, 1'b1);
        check_eq("R4 round2 R", {96'd0, c[31:0]}, {96'd0, R2});
        check_eq("R5 round2 L equals R1", {96'd0, c[63:32]}, {96'd0, R1});
        check_eq("R7 input register after loops", {64'd0, c[127:64]}, {64'd0, PT});

        // R10 / R2 hold: no load, no step, junk on pt_in
        func(1'b0, 64'h5555AAAA5555AAAA, 1'b0, 1'b1, K1, 1'b0);
        unload(c, '0, 1'b1);
        check_eq("R10 L/R held", {64'd0, c[63:0]}, {64'd0, R1, R2});
        check_eq("R2 input held", {64'd0, c[127:64]}, {64'd0, PT});

        // R9: scan_in high during functional clocks has no effect
        rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
        func(1'b1, PT, 1'b0, 1'b0, '0, 1'b1);
        func(1'b0, '0, 1'b1, 1'b1, K1, 1'b1);
        func(1'b0, '0, 1'b0, 1'b0, K2, 1'b1);
        unload(c, '0, 1'b1);
        check_eq("R9 state with scan_in high", c, {PT, L1, R1});

        // R6: shift a known pattern in, junk on functional inputs, read it back
        pat = 128'hA5C3_0F1E_8877_6655_0123_4567_89AB_CDEF;
        unload(c, pat, 1'b0);
        check_eq("R6 old state shifted out", c, {PT, L1, R1});
        check_eq("R6 first bit at scan_out", {127'd0, scan_out}, {127'd0, pat[0]});
        unload(c, '0, 1'b1);
        check_eq("R6 pattern order", c, pat);
        unload(c2, '0, 1'b1);
        check_eq("R7 second rotation", c2, pat);

        // R8: single-bit plaintext flips, all 64 positions
        for (int i = 0; i < 64; i++) begin
            d = PT ^ (64'd1 << i);
            func(1'b1, d, 1'b0, 1'b0, '0, 1'b0);
            unload(c, '0, 1'b1);
            check(($countones(c[127:64] ^ PT) == 1) && (c[64+i] != PT[i]),
                  $sformatf("R8 input diff bit %0d", i), {64'd0, c[127:64] ^ PT}, {64'd0, 64'd1 << i});
            func(1'b0, '0, 1'b1, 1'b1, K1, 1'b0);
            unload(c, '0, 1'b1);
            if (i % 2 == 0) begin
                check_eq($sformatf("R8 even bit %0d L unchanged", i), {96'd0, c[63:32]}, {96'd0, L1});
                check($countones(c[31:0] ^ R1) == 1, $sformatf("R8 even bit %0d one R bit", i),
                      {96'd0, c[31:0] ^ R1}, 128'd1);
                check($countones(c ^ {PT, L1, R1}) == 2, $sformatf("R8 even bit %0d two total", i),
                      c ^ {PT, L1, R1}, 128'd2);
            end else begin
                check($countones(c[63:32] ^ L1) == 1, $sformatf("R8 odd bit %0d one L bit", i),
                      {96'd0, c[63:32] ^ L1}, 128'd1);
            end
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end
endmodule